// File: doc/BRIEF.md
# Early Transmit Buffer Underrun Guard

This block lets a transmitter start sending a frame while the host is still copying that frame into buffer memory. It keeps a register holding the physical buffer address of the latest host write. It compares every DMA read of packet data with that register. When the DMA asks for an address beyond what the host has written so far, the DMA has overtaken the host. The block then raises an abort toward the transmitter and the DMA.

The abort stays up until the DMA reports that it has seen the abort and flushed the transmit FIFO. The event is reported in the same way as an ordinary FIFO underrun: a sticky transmit-status underrun bit and a sticky interrupt-status error bit are both set. Software clears them with an acknowledge strobe.

Checking is switched by a two-bit command with separate on and off bits. A command with neither bit set keeps the current state. A command with both bits set is illegal and is ignored. The host bus, the buffer memory and the DMA sequencer are outside the block and reach it only as address and strobe inputs.

Top module: `etx_underrun_guard`

## Requirements
- R1: After a synchronous active-low reset, `check_on`, `abort`, `tx_under` and `int_err` are all 0 and the latched write address is 0.
- R2: A command write (`cmd_wr`=1) with `cmd_on`=1 and `cmd_off`=0 sets `check_on` to 1 from the next clock edge.
- R3: A command write with `cmd_off`=1 and `cmd_on`=0 clears `check_on` to 0 from the next clock edge.
- R4: A command write with both bits 0 leaves `check_on` unchanged. A command write with both bits 1 is illegal and also leaves it unchanged.
- R5: A host buffer write (`host_wr`=1) loads `host_addr` into the latched write address only while `check_on` is 1. Writes made while checking is off leave the latch unchanged.
- R6: While `check_on` is 1, a DMA packet read (`dma_rd`=1, `dma_desc`=0) whose address is strictly greater than the latched address asserts `abort` from the next edge. A read at an address equal to or below the latch does not.
- R7: DMA reads flagged as descriptor-table accesses (`dma_desc`=1) never cause an abort, whatever their address.
- R8: While `check_on` is 0, no DMA read causes an abort.
- R9: Once asserted, `abort` stays 1 until a cycle with `fifo_clr`=1, and is 0 from the following edge. If a new underrun is detected in the same cycle as `fifo_clr`, `abort` stays 1.
- R10: The cycle `abort` is set, `tx_under` and `int_err` are both set. Both remain 1 until `stat_ack`=1, which clears them unless a new underrun is detected in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_on | input | 1 | Command bit: enable checking |
| cmd_off | input | 1 | Command bit: disable checking |
| host_wr | input | 1 | Host write to buffer memory |
| host_addr | input | ADDR_W | Physical memory address of the host write |
| dma_rd | input | 1 | DMA read from buffer memory |
| dma_desc | input | 1 | DMA read is a descriptor-table access |
| dma_addr | input | ADDR_W | Physical memory address of the DMA read |
| fifo_clr | input | 1 | DMA has seen the abort and cleared the transmit FIFO |
| stat_ack | input | 1 | Clear both status bits |
| check_on | output | 1 | Checking is enabled |
| abort | output | 1 | Buffer-underrun abort to transmitter and DMA |
| tx_under | output | 1 | Transmit-status underrun bit (sticky) |
| int_err | output | 1 | Interrupt-status error bit (sticky) |

## Verification
The assertions check the following on every cycle:
- The command decode keeps `check_on` steady for idle, null and illegal commands.
- The latch changes only on host writes made while checking is on.
- A rise of `abort` always follows an enabled packet read, never a descriptor read, and always comes with both status bits set.
- `abort` holds until a FIFO clear.

Some behaviours only the bench's scenarios can show:
- The address ordering itself: equal is safe, one above trips.
- A write made while checking was off really leaves the old address in the latch.
- Priority when a trip coincides with a FIFO clear or a status acknowledge.

// File: rtl/etug_pkg.sv
// Package: shared types for the early transmit underrun guard.
// Assumes: a command is decoded from two independent bits (on, off).
package etug_pkg;
    typedef enum logic [1:0] {
        CMD_KEEP    = 2'b00,
        CMD_OFF     = 2'b01,
        CMD_ON      = 2'b10,
        CMD_ILLEGAL = 2'b11
    } etug_cmd_e;
endpackage

// File: rtl/etug_cmd_ctl.sv
// Module: checking enable register driven by the on/off command pair.
// Assumes: cmd_wr qualifies cmd_on/cmd_off; illegal pair is ignored.
module etug_cmd_ctl
    import etug_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_on,
    input  logic cmd_off,
    output logic check_on
);
    etug_cmd_e cmd;
    logic      check_q;

    // Form the command code from the two command bits.
    always_comb begin
        cmd = etug_cmd_e'({cmd_on, cmd_off});
    end

    // Update the enable state on legal on/off commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            check_q <= 1'b0;
        end else if (cmd_wr) begin
            case (cmd)
                CMD_ON:  check_q <= 1'b1;
                CMD_OFF: check_q <= 1'b0;
                default: check_q <= check_q;
            endcase
        end
    end

    assign check_on = check_q;
endmodule

// File: rtl/etug_addr_latch.sv
// Module: holds the physical address of the latest host buffer write.
// Assumes: host_addr is already the memory address, not the bus address.
module etug_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_on,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [ADDR_W-1:0] wr_mark
);
    logic [ADDR_W-1:0] mark_q;

    // Capture the write address only while checking is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else if (host_wr && check_on) begin
            mark_q <= host_addr;
        end
    end

    assign wr_mark = mark_q;
endmodule

// File: rtl/etug_cmp.sv
// Module: combinational overtake detector for DMA packet-data reads.
// Assumes: unsigned addresses; a same-cycle host write is not yet visible.
module etug_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              check_on,
    input  logic              dma_rd,
    input  logic              dma_desc,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [ADDR_W-1:0] wr_mark,
    output logic              trip
);
    logic pkt_rd;

    // Flag a packet read that runs past the latched write address.
    always_comb begin
        pkt_rd = dma_rd && !dma_desc;
        trip   = check_on && pkt_rd && (dma_addr > wr_mark);
    end
endmodule

// File: rtl/etug_status.sv
// Module: abort flag and the two sticky status bits.
// Assumes: a new trip wins over a same-cycle clear or acknowledge.
module etug_status #(
    parameter int N_STAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic fifo_clr,
    input  logic stat_ack,
    output logic abort,
    output logic [N_STAT-1:0] stat
);
    logic abort_q;

    // Hold the abort until the DMA reports a cleared FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else if (trip) begin
            abort_q <= 1'b1;
        end else if (fifo_clr) begin
            abort_q <= 1'b0;
        end
    end

    // One sticky bit per reported status, set together on a trip.
    for (genvar i = 0; i < N_STAT; i++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat[i] <= 1'b0;
            end else if (trip) begin
                stat[i] <= 1'b1;
            end else if (stat_ack) begin
                stat[i] <= 1'b0;
            end
        end
    end

    assign abort = abort_q;
endmodule

// File: rtl/etx_underrun_guard.sv
// Module: top of the early transmit buffer underrun guard.
// Assumes: all strobes are single-cycle and synchronous to clk.
module etx_underrun_guard #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_on,
    input  logic              cmd_off,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              dma_rd,
    input  logic              dma_desc,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              fifo_clr,
    input  logic              stat_ack,
    output logic              check_on,
    output logic              abort,
    output logic              tx_under,
    output logic              int_err
);
    localparam int N_STAT = 2;

    logic [ADDR_W-1:0] wr_mark;
    logic              trip;
    logic [N_STAT-1:0] stat;

    etug_cmd_ctl u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .cmd_on(cmd_on), .cmd_off(cmd_off), .check_on(check_on)
    );

    etug_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .check_on(check_on),
        .host_wr(host_wr), .host_addr(host_addr), .wr_mark(wr_mark)
    );

    etug_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .check_on(check_on), .dma_rd(dma_rd), .dma_desc(dma_desc),
        .dma_addr(dma_addr), .wr_mark(wr_mark), .trip(trip)
    );

    etug_status #(.N_STAT(N_STAT)) u_stat (
        .clk(clk), .rst_n(rst_n), .trip(trip), .fifo_clr(fifo_clr),
        .stat_ack(stat_ack), .abort(abort), .stat(stat)
    );

    assign tx_under = stat[0];
    assign int_err  = stat[1];
endmodule

// File: rtl/etx_underrun_guard_chk.sv
// Module: assertion checker bound to the underrun guard top.
// Assumes: sees the top's ports plus the latched write address.
module etx_underrun_guard_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              cmd_on,
    input logic              cmd_off,
    input logic              host_wr,
    input logic              dma_rd,
    input logic              dma_desc,
    input logic              fifo_clr,
    input logic              check_on,
    input logic              abort,
    input logic              tx_under,
    input logic              int_err,
    input logic [ADDR_W-1:0] wr_mark
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !check_on && !abort && !tx_under && !int_err); // R1
    AST_CMD_ON: assert property (@(posedge clk) disable iff (!rst_n) cmd_wr && cmd_on && !cmd_off |=> check_on); // R2
    AST_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n) cmd_wr && cmd_off && !cmd_on |=> !check_on); // R3
    AST_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (!cmd_wr || (cmd_on == cmd_off)) |=> $stable(check_on)); // R4
    AST_MARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(host_wr && check_on) |=> $stable(wr_mark)); // R5
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort) |-> $past(dma_rd && check_on)); // R6
    AST_NO_DESC_TRIP: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort) |-> !$past(dma_desc)); // R7
    AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n) !check_on && !abort |=> !abort); // R8
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) abort && !fifo_clr |=> abort); // R9
    AST_STAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort) |-> tx_under && int_err); // R10
endmodule

bind etx_underrun_guard etx_underrun_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_on(cmd_on),
    .cmd_off(cmd_off), .host_wr(host_wr), .dma_rd(dma_rd),
    .dma_desc(dma_desc), .fifo_clr(fifo_clr), .check_on(check_on),
    .abort(abort), .tx_under(tx_under), .int_err(int_err), .wr_mark(wr_mark)
);

// File: tb/etx_underrun_guard_bench.sv
// Bench: vector table walk, then directed reset and priority cases.
module etx_underrun_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int N_VEC      = 20;

    // Row kinds: 0 on, 1 off, 2 keep(00), 3 illegal(11), 4 host write,
    // 5 DMA packet read, 6 DMA descriptor read, 7 FIFO clear.
    // Row layout: {kind[2:0], addr[15:0], exp_check_on, exp_abort}
    localparam logic [20:0] VEC [N_VEC] = '{
        {3'd4, 16'h0100, 1'b0, 1'b0},  // R5 write while off
        {3'd0, 16'h0000, 1'b1, 1'b0},  // R2
        {3'd5, 16'h0001, 1'b1, 1'b1},  // R5/R6 latch still 0
        {3'd7, 16'h0000, 1'b1, 1'b0},  // R9
        {3'd4, 16'h0100, 1'b1, 1'b0},  // R5
        {3'd5, 16'h0100, 1'b1, 1'b0},  // R6 equal
        {3'd5, 16'h00FF, 1'b1, 1'b0},  // R6 below
        {3'd6, 16'h0200, 1'b1, 1'b0},  // R7
        {3'd5, 16'h0101, 1'b1, 1'b1},  // R6 one above
        {3'd5, 16'h0050, 1'b1, 1'b1},  // R9 held
        {3'd7, 16'h0000, 1'b1, 1'b0},  // R9
        {3'd2, 16'h0000, 1'b1, 1'b0},  // R4 keep
        {3'd3, 16'h0000, 1'b1, 1'b0},  // R4 illegal
        {3'd1, 16'h0000, 1'b0, 1'b0},  // R3
        {3'd5, 16'hFFFF, 1'b0, 1'b0},  // R8
        {3'd4, 16'h0400, 1'b0, 1'b0},  // R5 write while off
        {3'd3, 16'h0000, 1'b0, 1'b0},  // R4 illegal
        {3'd0, 16'h0000, 1'b1, 1'b0},  // R2
        {3'd5, 16'h0101, 1'b1, 1'b1},  // R5 latch kept 0x0100
        {3'd7, 16'h0000, 1'b1, 1'b0}   // R9
    };

    logic clk = 1'b0;
    logic rst_n, cmd_wr, cmd_on, cmd_off, host_wr, dma_rd, dma_desc, fifo_clr, stat_ack;
    logic [ADDR_W-1:0] host_addr, dma_addr;
    logic check_on, abort, tx_under, int_err;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    etx_underrun_guard #(.ADDR_W(ADDR_W)) u_etx_underrun_guard (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_on(cmd_on),
        .cmd_off(cmd_off), .host_wr(host_wr), .host_addr(host_addr),
        .dma_rd(dma_rd), .dma_desc(dma_desc), .dma_addr(dma_addr),
        .fifo_clr(fifo_clr), .stat_ack(stat_ack), .check_on(check_on),
        .abort(abort), .tx_under(tx_under), .int_err(int_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_wr = 0; cmd_on = 0; cmd_off = 0; host_wr = 0; host_addr = '0;
        dma_rd = 0; dma_desc = 0; dma_addr = '0; fifo_clr = 0; stat_ack = 0;
    endtask

    // Drive one row at the falling edge, then sample 1 unit after the rising edge.
    task automatic apply(input logic [2:0] kind, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        idle();
        case (kind)
            3'd0: begin cmd_wr = 1; cmd_on = 1; end
            3'd1: begin cmd_wr = 1; cmd_off = 1; end
            3'd2: begin cmd_wr = 1; end
            3'd3: begin cmd_wr = 1; cmd_on = 1; cmd_off = 1; end
            3'd4: begin host_wr = 1; host_addr = a; end
            3'd5: begin dma_rd = 1; dma_addr = a; end
            3'd6: begin dma_rd = 1; dma_desc = 1; dma_addr = a; end
            default: fifo_clr = 1;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle();
        rst_n = 0;
        do_reset();
        check("R1 check_on", check_on, 1'b0);
        check("R1 abort", abort, 1'b0);
        check("R1 tx_under", tx_under, 1'b0);
        check("R1 int_err", int_err, 1'b0);

        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i][20:18], VEC[i][17:2]);
            check($sformatf("R2/R3/R4 row %0d check_on", i), check_on, VEC[i][1]);
            check($sformatf("R5/R6/R7/R8/R9 row %0d abort", i), abort, VEC[i][0]);
        end

        // R10: both status bits are sticky after the table's trips.
        check("R10 tx_under sticky", tx_under, 1'b1);
        check("R10 int_err sticky", int_err, 1'b1);
        @(negedge clk); idle(); stat_ack = 1;
        @(posedge clk); #1;
        check("R10 tx_under cleared", tx_under, 1'b0);
        check("R10 int_err cleared", int_err, 1'b0);

        // R9: a trip in the same cycle as fifo_clr keeps abort set.
        apply(3'd5, 16'h0200);
        check("R9 abort set", abort, 1'b1);
        @(negedge clk); idle(); fifo_clr = 1; dma_rd = 1; dma_addr = 16'h0300;
        @(posedge clk); #1;
        check("R9 trip beats fifo_clr", abort, 1'b1);

        // R10: a trip in the same cycle as stat_ack keeps the status set.
        @(negedge clk); idle(); stat_ack = 1; dma_rd = 1; dma_addr = 16'h0300;
        @(posedge clk); #1;
        check("R10 trip beats ack tx_under", tx_under, 1'b1);
        check("R10 trip beats ack int_err", int_err, 1'b1);

        // R1: reset mid-run clears everything, including the latch (packet read of 1 trips).
        do_reset();
        check("R1 re-reset abort", abort, 1'b0);
        check("R1 re-reset tx_under", tx_under, 1'b0);
        check("R1 re-reset check_on", check_on, 1'b0);
        apply(3'd0, '0);
        apply(3'd5, 16'h0000);
        check("R1 latch zero, equal read safe", abort, 1'b0);
        apply(3'd5, 16'h0001);
        check("R1 latch zero, read 1 trips", abort, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule